// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a 32-bit virtual address into a 30-bit physical address by looking up one entry in a flat page table held in memory. Pages are 4 KB. The low 12 address bits are the page offset and pass through unchanged. The upper 20 bits are the virtual page number, and they index the table directly from a base address held in a register inside the block. Each translation fetches exactly one 32-bit entry. Only the entry's valid flag decides hit or miss, because every mapping lives in the table and there is no tag compare. A hit joins the entry's 18-bit physical page number with the offset. A miss reports a page fault and records the faulting page number for the handler.

The processor side has two valid/ready streams. A request stream carries the virtual address, and a response stream carries the physical address and the fault flag. A request is taken only while the block is idle, so at most one translation is in flight. A response is held with stable contents until the consumer takes it, and the block stalls in the meantime. The memory side is a valid/ready read-address channel plus a read-data valid strobe, and that strobe cannot be back-pressured. The table base is loaded through its own valid/ready write channel. The write is accepted only while the block is idle, so a context switch cannot disturb a walk in flight.

Top module: `pt_xlate`

## Requirements
- R1: After reset, `req_ready` and `base_wr_ready` are 1, while `rsp_valid`, `mem_rd_valid`, `rsp_fault`, `rsp_paddr` and `fault_vpn` are 0.
- R2: After a request is accepted, `mem_rd_valid` rises and `mem_rd_addr` equals base + (vaddr[31:12] × 4). Both hold unchanged until `mem_rd_ready` is seen high.
- R3: When the fetched entry has bit 31 = 1 (present), the response carries `rsp_fault` = 0 and `rsp_paddr` = {entry[17:0], vaddr[11:0]}.
- R4: When the fetched entry has bit 31 = 0, the response carries `rsp_fault` = 1 and `rsp_paddr` = 0, and `fault_vpn` takes vaddr[31:12]. `fault_vpn` keeps that value through later translations that do not fault.
- R5: Only one translation is in flight at a time. `req_ready` stays 0 from acceptance until the response is taken, and exactly one memory read is issued for each translation.
- R6: `rsp_valid` stays 1, with `rsp_paddr` and `rsp_fault` unchanged, until `rsp_ready` is seen high. The block then returns to idle in the next cycle.
- R7: A `mem_rsp_valid` strobe that arrives before the read address has been accepted is ignored. No response is produced from it.
- R8: `base_wr_ready` is 0 while a translation is in flight, and a base write offered then is not taken. The next translation still uses the old base.
- R9: If a base write and a request are both offered in the same idle cycle, the write is taken first and `req_ready` is 0 in that cycle. The request is then accepted and uses the new base.
- R10: Entry bits 30:18 have no effect on the response.
- R11: The entry address is computed modulo 2^32, so base + offset wraps past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 30 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page not present |
| fault_vpn | output | 20 | Page number of the most recent fault |
| mem_rd_valid | output | 1 | Entry read address offered |
| mem_rd_ready | input | 1 | Memory accepts the read address |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Fetched table entry |
| base_wr_valid | input | 1 | New table base offered |
| base_wr_ready | output | 1 | Base write can be taken |
| base_wr_data | input | 32 | New table base address |

## Verification
The bench builds the block with its default parameters: 32-bit virtual and entry addresses, a 30-bit physical address, a 12-bit offset and 4-byte entries. At these sizes the all-ones page number, the 18-bit page number field next to the ignored entry bits, and a base near 2^32 whose entry address wraps to a small value are all reachable. Varying the read-ready delay, the data latency and the response back-pressure within each directed test exercises the hold rules on both streams.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_RESPOND = 2'd2
  } walk_state_e;

endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_en,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_data,
  output logic              wr_ready,
  output logic [ADDR_W-1:0] base_q
);

  // writes are only taken while no walk is using the base
  assign wr_ready = accept_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr_valid && wr_ready) begin
      base_q <= wr_data;
    end
  end

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_xlate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic mem_rd_ready,
  input  logic mem_rsp_valid,
  input  logic rsp_ready,
  output logic idle,
  output logic rd_valid,
  output logic rsp_capture,
  output logic rsp_valid
);

  walk_state_e state_q, state_d;
  logic        sent_q, sent_d;

  assign idle        = (state_q == ST_IDLE);
  assign rd_valid    = (state_q == ST_FETCH) && !sent_q;
  // data strobes count only after the address has gone out
  assign rsp_capture = (state_q == ST_FETCH) && sent_q && mem_rsp_valid;
  assign rsp_valid   = (state_q == ST_RESPOND);

  always_comb begin
    state_d = state_q;
    sent_d  = sent_q;
    unique case (state_q)
      ST_IDLE: begin
        sent_d = 1'b0;
        if (req_fire) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (rd_valid && mem_rd_ready) sent_d = 1'b1;
        if (rsp_capture)              state_d = ST_RESPOND;
      end
      ST_RESPOND: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sent_q  <= sent_d;
    end
  end

endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
  parameter int ENTRY_W   = 32,
  parameter int VALID_BIT = 31,
  parameter int PPN_W     = 18,
  parameter int OFF_W     = 12,
  localparam int PA_W     = PPN_W + OFF_W
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [OFF_W-1:0]   offset,
  output logic               present,
  output logic [PA_W-1:0]    paddr
);

  logic entry_unused_parity;

  assign present = entry[VALID_BIT];
  assign paddr   = present ? {entry[PPN_W-1:0], offset} : '0;

  // remaining entry bits are reserved and deliberately ignored
  assign entry_unused_parity = ^entry;

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int VA_W            = 32,
  parameter int PA_W            = 30,
  parameter int PAGE_OFF_W      = 12,
  parameter int ADDR_W          = 32,
  parameter int ENTRY_W         = 32,
  parameter int ENTRY_VALID_BIT = 31,
  localparam int VPN_W          = VA_W - PAGE_OFF_W,
  localparam int PPN_W          = PA_W - PAGE_OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_fault,
  output logic [VPN_W-1:0]   fault_vpn,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  input  logic               base_wr_valid,
  output logic               base_wr_ready,
  input  logic [ADDR_W-1:0]  base_wr_data
);

  localparam int ENTRY_BYTES = ENTRY_W / 8;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

  logic                  idle;
  logic                  req_fire;
  logic                  rsp_capture;
  logic [ADDR_W-1:0]     base_q;
  logic [VPN_W-1:0]      vpn_q;
  logic [PAGE_OFF_W-1:0] off_q;
  logic [ADDR_W-1:0]     vpn_ext;
  logic                  dec_present;
  logic [PA_W-1:0]       dec_paddr;
  logic [PA_W-1:0]       paddr_q;
  logic                  fault_q;
  logic [VPN_W-1:0]      fault_vpn_q;

  // a pending base write beats a request in the same idle cycle
  assign req_ready = idle && !base_wr_valid;
  assign req_fire  = req_valid && req_ready;

  pt_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_en (idle),
    .wr_valid  (base_wr_valid),
    .wr_data   (base_wr_data),
    .wr_ready  (base_wr_ready),
    .base_q    (base_q)
  );

  pt_walk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_fire      (req_fire),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_ready     (rsp_ready),
    .idle          (idle),
    .rd_valid      (mem_rd_valid),
    .rsp_capture   (rsp_capture),
    .rsp_valid     (rsp_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpn_q <= '0;
      off_q <= '0;
    end else if (req_fire) begin
      vpn_q <= req_vaddr[VA_W-1:PAGE_OFF_W];
      off_q <= req_vaddr[PAGE_OFF_W-1:0];
    end
  end

  // entry address wraps modulo 2^ADDR_W
  generate
    if (ADDR_W > VPN_W) begin : g_vpn_pad
      assign vpn_ext = {{(ADDR_W-VPN_W){1'b0}}, vpn_q};
    end else begin : g_vpn_trim
      assign vpn_ext = vpn_q[ADDR_W-1:0];
    end
  endgenerate

  assign mem_rd_addr = base_q + (vpn_ext << ENTRY_SHIFT);

  pt_entry_decode #(
    .ENTRY_W   (ENTRY_W),
    .VALID_BIT (ENTRY_VALID_BIT),
    .PPN_W     (PPN_W),
    .OFF_W     (PAGE_OFF_W)
  ) u_dec (
    .entry   (mem_rsp_data),
    .offset  (off_q),
    .present (dec_present),
    .paddr   (dec_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      paddr_q     <= '0;
      fault_q     <= 1'b0;
      fault_vpn_q <= '0;
    end else if (rsp_capture) begin
      paddr_q <= dec_paddr;
      fault_q <= !dec_present;
      if (!dec_present) fault_vpn_q <= vpn_q;
    end
  end

  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;
  assign fault_vpn = fault_vpn_q;

endmodule

// File: rtl/pt_xlate_checker.sv
module pt_xlate_checker #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 30,
  parameter int PAGE_OFF_W = 12,
  parameter int ADDR_W     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              rsp_fault,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              base_wr_valid
);

  logic [PAGE_OFF_W-1:0] exp_off_q;
  logic [1:0]            reads_q;
  logic                  vaddr_unused_hi;

  assign vaddr_unused_hi = ^req_vaddr[VA_W-1:PAGE_OFF_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_off_q <= '0;
      reads_q   <= 2'd0;
    end else if (req_valid && req_ready) begin
      exp_off_q <= req_vaddr[PAGE_OFF_W-1:0];
      reads_q   <= 2'd0;
    end else if (mem_rd_valid && mem_rd_ready && reads_q != 2'd3) begin
      reads_q <= reads_q + 2'd1;
    end
  end

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[PAGE_OFF_W-1:0] == exp_off_q);

  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_valid) |-> !req_ready);

  assert_one_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> reads_q == 2'd1);

  assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  assert_write_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_valid |-> !req_ready);

endmodule

bind pt_xlate pt_xlate_checker #(
  .VA_W       (VA_W),
  .PA_W       (PA_W),
  .PAGE_OFF_W (PAGE_OFF_W),
  .ADDR_W     (ADDR_W)
) u_pt_xlate_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_fault     (rsp_fault),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_ready  (mem_rd_ready),
  .mem_rd_addr   (mem_rd_addr),
  .base_wr_valid (base_wr_valid)
);

// File: tb/pt_xlate_bench.sv
module pt_xlate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [29:0] rsp_paddr;
  logic        rsp_fault;
  logic [19:0] fault_vpn;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        base_wr_valid = 1'b0;
  logic        base_wr_ready;
  logic [31:0] base_wr_data = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pt_xlate u_pt_xlate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .fault_vpn(fault_vpn),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .base_wr_valid(base_wr_valid), .base_wr_ready(base_wr_ready), .base_wr_data(base_wr_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_base(input logic [31:0] val);
    @(negedge clk);
    base_wr_valid = 1'b1;
    base_wr_data  = val;
    #1;
    while (!base_wr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    base_wr_valid = 1'b0;
  endtask

  // one full translation; options shape the handshakes
  task automatic run_xlate(input logic [31:0] vaddr, input logic [31:0] entry,
                           input logic [31:0] exp_addr,
                           input int rd_delay, input int lat, input int hold,
                           input bit spurious, input bit busy_wr, input bit wr_with_req,
                           input logic [31:0] wr_val, input string tag);
    logic [29:0] exp_pa;
    logic        exp_fault;
    exp_fault = !entry[31];
    exp_pa    = exp_fault ? 30'd0 : {entry[17:0], vaddr[11:0]};
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = vaddr;
    if (wr_with_req) begin
      base_wr_valid = 1'b1;
      base_wr_data  = wr_val;
      #1;
      chk(req_ready == 1'b0, {tag, " R9 req_ready low with write"}, {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      base_wr_valid = 1'b0;
    end
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {tag, " R5 busy after accept"}, {31'd0, req_ready}, 32'd0);
    chk(mem_rd_valid == 1'b1, {tag, " R2 read issued"}, {31'd0, mem_rd_valid}, 32'd1);
    chk(mem_rd_addr == exp_addr, {tag, " R2/R11 entry address"}, mem_rd_addr, exp_addr);
    for (int i = 0; i < rd_delay; i++) begin
      if (spurious && i == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'h8000_0001;
      end
      if (busy_wr && i == 0) begin
        base_wr_valid = 1'b1;
        base_wr_data  = wr_val;
        #1;
        chk(base_wr_ready == 1'b0, {tag, " R8 write refused while busy"}, {31'd0, base_wr_ready}, 32'd0);
      end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      base_wr_valid = 1'b0;
      chk(mem_rd_valid && mem_rd_addr == exp_addr, {tag, " R2 address held"}, mem_rd_addr, exp_addr);
      if (spurious) chk(rsp_valid == 1'b0, {tag, " R7 early strobe ignored"}, {31'd0, rsp_valid}, 32'd0);
    end
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    chk(mem_rd_valid == 1'b0, {tag, " R5 single read"}, {31'd0, mem_rd_valid}, 32'd0);
    for (int i = 0; i < lat; i++) @(negedge clk);
    chk(rsp_valid == 1'b0, {tag, " R6 no response before data"}, {31'd0, rsp_valid}, 32'd0);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = entry;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    chk(rsp_valid == 1'b1, {tag, " R6 response valid"}, {31'd0, rsp_valid}, 32'd1);
    chk(rsp_fault == exp_fault, {tag, " R3/R4 fault flag"}, {31'd0, rsp_fault}, {31'd0, exp_fault});
    chk(rsp_paddr == exp_pa, {tag, " R3/R4/R10 physical address"}, {2'd0, rsp_paddr}, {2'd0, exp_pa});
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == exp_pa && rsp_fault == exp_fault,
          {tag, " R6 response held"}, {2'd0, rsp_paddr}, {2'd0, exp_pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, {tag, " R6 back to idle"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk(base_wr_ready == 1'b1, "R1 base_wr_ready", {31'd0, base_wr_ready}, 32'd1);
    chk(!rsp_valid && !mem_rd_valid && !rsp_fault, "R1 valids low", {29'd0, rsp_valid, mem_rd_valid, rsp_fault}, 32'd0);
    chk(rsp_paddr == 30'd0 && fault_vpn == 20'd0, "R1 data zero", {12'd0, fault_vpn}, 32'd0);
  endtask

  task automatic t_hit;
    write_base(32'h0010_0000);
    run_xlate(32'h1234_5ABC, 32'h8002_1357, 32'h0010_0000 + (32'h12345 << 2),
              0, 0, 0, 1'b0, 1'b0, 1'b0, 32'd0, "hit R3");
  endtask

  task automatic t_fault;
    run_xlate(32'hDEAD_BFFF, 32'h7FFF_FFFF, 32'h0010_0000 + (32'hDEADB << 2),
              1, 1, 1, 1'b0, 1'b0, 1'b0, 32'd0, "fault R4");
    chk(fault_vpn == 20'hDEADB, "R4 fault_vpn latched", {12'd0, fault_vpn}, 32'h000D_EADB);
  endtask

  task automatic t_junk_bits;
    run_xlate(32'h0000_1FFE, 32'hFFFF_ABCD, 32'h0010_0004,
              3, 2, 3, 1'b0, 1'b0, 1'b0, 32'd0, "reserved R10");
    chk(fault_vpn == 20'hDEADB, "R4 fault_vpn kept after hit", {12'd0, fault_vpn}, 32'h000D_EADB);
  endtask

  task automatic t_spurious;
    run_xlate(32'h0004_2010, 32'h8000_0777, 32'h0010_0000 + (32'h00042 << 2),
              2, 0, 0, 1'b1, 1'b0, 1'b0, 32'd0, "spurious R7");
  endtask

  task automatic t_busy_write;
    run_xlate(32'h0000_0000, 32'h8000_0001, 32'h0010_0000,
              2, 1, 0, 1'b0, 1'b1, 1'b0, 32'hAAAA_0000, "busywr R8");
    run_xlate(32'h0000_2000, 32'h8000_0002, 32'h0010_0008,
              0, 0, 0, 1'b0, 1'b0, 1'b0, 32'd0, "old base R8");
  endtask

  task automatic t_write_first;
    run_xlate(32'h0000_5123, 32'h8003_FFFF, 32'h0000_0004,
              0, 0, 1, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFF0, "wrfirst R9 R11");
  endtask

  task automatic t_top_page;
    write_base(32'h0000_0000);
    run_xlate(32'hFFFF_FFFF, 32'h0000_0000, 32'h003F_FFFC,
              0, 0, 0, 1'b0, 1'b0, 1'b0, 32'd0, "toppage R4");
    chk(fault_vpn == 20'hFFFFF, "R4 fault_vpn top", {12'd0, fault_vpn}, 32'h000F_FFFF);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hit();
    t_fault();
    t_junk_bits();
    t_spurious();
    t_busy_write();
    t_write_first();
    t_top_page();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule